// File: doc/BRIEF.md
# TLB-Miss Walk Gating Controller

This block decides the cycle in which a hardware page-table walk may begin after a translation miss. Three sources can ask for a walk: the instruction-side translation buffer, the data-side translation buffer (a change-bit update also counts as a data-side request), and line fetches issued by the vector prefetch (touch) queue. Each source has its own start conditions, taken from pipeline status flags. Only one walk runs at a time. When more than one source is eligible in the same cycle, a fixed priority picks the winner.

A request is captured in a pending register and stays there until it is granted or cancelled by a flush. The grant is a one-cycle, one-hot pulse that starts the walker and moves the controller into its walking state. While a walk runs, the block holds a busy output that stops store gathering. When the walker signals done, the controller returns a success or fault pulse to the source that owns the walk, then goes back to idle. For a data access that is misaligned across a translation boundary, the block also signals either an automatic resume of the second part or a restart of the whole access. The walker datapath, the entry format and the translation arrays lie outside this block.

Top module: `walk_gate_ctrl`

## Requirements
- R1: An instruction-side pending request (grant bit 0) is granted only when `cb_empty`, `csq_empty` and `ibuf_empty` are all 1 and `exc_pending` is 0. Lowering any one of these flags alone blocks the grant.
- R2: A data-side pending request (grant bit 1) is granted only when `dacc_required` is 1 and `exc_pending` is 0.
- R3: A prefetch-queue pending request (grant bit 2) is not granted while `pf_retired` is 0, and it stays pending while it waits.
- R4: A pending prefetch-queue request is granted in the first idle cycle in which `pf_retired` is 1 and no higher-priority source is eligible.
- R5: `grant` is one-hot or zero. It is issued only in the idle state, and it is never issued while a walk is in progress. When several sources are eligible together, bit 0 beats bit 1 and bit 1 beats bit 2.
- R6: A request pulse on a source's request input is held as pending, starting the next cycle, until that source is granted. A `flush` cycle clears every pending request and blocks any grant in that cycle.
- R7: `busy` is 0 in idle. It is 1 from the cycle after a grant through the cycle in which `walk_done` is seen.
- R8: In a cycle where `busy` and `walk_done` are both 1, exactly one of `rsp_ok` or `rsp_fault` (chosen by `walk_fault`) pulses, on the bit of the source that owns the walk. Both are 0 in every other cycle. The next cycle is idle.
- R9: For a data-side walk whose request carried `dmiss_cross` = 1, a successful completion pulses `mis_resume`. A faulting completion pulses `mis_restart` together with `rsp_fault` bit 1.
- R10: `lookup_open` is 1 in idle and during a prefetch-queue walk. It is 0 during an instruction-side or data-side walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| imiss_req | input | 1 | Instruction-side miss request pulse |
| dmiss_req | input | 1 | Data-side miss or change-bit update request pulse |
| dmiss_cross | input | 1 | Data request is the second part of a boundary-crossing misaligned access |
| pf_req | input | 1 | Prefetch-queue line fetch needs a walk |
| pf_retired | input | 1 | Prefetch instruction that owns the line fetch has retired |
| flush | input | 1 | Cancel all pending requests |
| cb_empty | input | 1 | Completion buffer empty |
| csq_empty | input | 1 | Completed-store queue empty |
| ibuf_empty | input | 1 | Instruction buffer empty |
| exc_pending | input | 1 | Another exception is pending |
| dacc_required | input | 1 | Data access confirmed as required by program flow |
| walk_done | input | 1 | Walker has finished |
| walk_fault | input | 1 | Finished walk ended in a fault |
| grant | output | 3 | One-hot walk start pulse: bit 0 instruction, bit 1 data, bit 2 prefetch |
| busy | output | 1 | Walk in progress; stops store gathering |
| rsp_ok | output | 3 | Success pulse to the owning source |
| rsp_fault | output | 3 | Fault pulse to the owning source |
| mis_resume | output | 1 | Misaligned second part completes automatically |
| mis_restart | output | 1 | Misaligned access restarts from its first part after the handler |
| lookup_open | output | 1 | Translation lookups stay available to the fetch and load/store units |

## Verification
The bench builds the block with its default source count of three, so that all three request channels exist. That lets it create three-way collisions, priority ordering between them, and a prefetch request that waits behind a not-yet-retired instruction while the other two sources are served. Directed sequences lower each gating flag on its own, place a flush between a request and its grant, and complete a boundary-crossing data walk once with success and once with a fault. Seeded random stimulus then covers overlapping requests, flushes and completions against a bench-side expectation.

// File: rtl/wgc_pkg.sv
package wgc_pkg;
   typedef enum logic {
      WS_IDLE = 1'b0,
      WS_WALK = 1'b1
   } wstate_e;

   localparam int SRC_INS = 0;
   localparam int SRC_DAT = 1;
   localparam int SRC_PFQ = 2;
   localparam int SRC_COUNT = 3;
endpackage

// File: rtl/wgc_hold.sv
module wgc_hold (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic taken_i,
   input  logic flush_i,
   output logic pend_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pend_o <= 1'b0;
      else if (flush_i) pend_o <= 1'b0;
      else              pend_o <= (pend_o & ~taken_i) | set_i;
   end

   // R6: a pending request not taken and not flushed survives
   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_o && !taken_i && !flush_i) |=> pend_o);
endmodule

// File: rtl/wgc_arb.sv
module wgc_arb #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en_i,
   input  logic [N-1:0] elig_i,
   output logic [N-1:0] gnt_o
);
   logic [N:0] blocked;

   always_comb begin
      blocked[0] = 1'b0;
      for (int i = 0; i < N; i++) begin
         gnt_o[i]     = en_i & elig_i[i] & ~blocked[i];
         blocked[i+1] = blocked[i] | elig_i[i];
      end
   end

   // R5: a grant always lands on an eligible source
   p_gnt_elig_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ((gnt_o & ~elig_i) == '0));
endmodule

// File: rtl/wgc_fsm.sv
module wgc_fsm
   import wgc_pkg::*;
#(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] gnt_i,
   input  logic         cross_i,
   input  logic         done_i,
   output wstate_e      state_o,
   output logic [N-1:0] owner_o,
   output logic         cross_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_o <= WS_IDLE;
         owner_o <= '0;
         cross_o <= 1'b0;
      end else begin
         case (state_o)
            WS_IDLE: if (|gnt_i) begin
               state_o <= WS_WALK;
               owner_o <= gnt_i;
               cross_o <= gnt_i[SRC_DAT] & cross_i;
            end
            WS_WALK: if (done_i) state_o <= WS_IDLE;
            default: state_o <= WS_IDLE;
         endcase
      end
   end

   // R8: the owner of a running walk is exactly one source
   p_owner_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == WS_WALK) |-> $onehot(owner_o));
endmodule

// File: rtl/walk_gate_ctrl.sv
module walk_gate_ctrl
   import wgc_pkg::*;
#(
   parameter int NSRC = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            imiss_req,
   input  logic            dmiss_req,
   input  logic            dmiss_cross,
   input  logic            pf_req,
   input  logic            pf_retired,
   input  logic            flush,
   input  logic            cb_empty,
   input  logic            csq_empty,
   input  logic            ibuf_empty,
   input  logic            exc_pending,
   input  logic            dacc_required,
   input  logic            walk_done,
   input  logic            walk_fault,
   output logic [NSRC-1:0] grant,
   output logic            busy,
   output logic [NSRC-1:0] rsp_ok,
   output logic [NSRC-1:0] rsp_fault,
   output logic            mis_resume,
   output logic            mis_restart,
   output logic            lookup_open
);
   if (NSRC != SRC_COUNT) begin : g_bad_nsrc
      $error("walk_gate_ctrl: NSRC must equal the number of request sources");
   end

   logic [NSRC-1:0] req_vec, pend, elig, owner;
   logic            dcross_q, walk_cross, fin;
   wstate_e         state;

   assign req_vec[SRC_INS] = imiss_req;
   assign req_vec[SRC_DAT] = dmiss_req;
   assign req_vec[SRC_PFQ] = pf_req;

   for (genvar s = 0; s < NSRC; s++) begin : g_hold
      wgc_hold u_hold (
         .clk     (clk),
         .rst_n   (rst_n),
         .set_i   (req_vec[s]),
         .taken_i (grant[s]),
         .flush_i (flush),
         .pend_o  (pend[s])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         dcross_q <= 1'b0;
      else if (flush)     dcross_q <= 1'b0;
      else if (dmiss_req) dcross_q <= dmiss_cross;
   end

   assign elig[SRC_INS] = pend[SRC_INS] & cb_empty & csq_empty & ibuf_empty
                          & ~exc_pending & ~flush;
   assign elig[SRC_DAT] = pend[SRC_DAT] & dacc_required & ~exc_pending & ~flush;
   assign elig[SRC_PFQ] = pend[SRC_PFQ] & pf_retired & ~flush;

   wgc_arb #(.N(NSRC)) u_arb (
      .clk    (clk),
      .rst_n  (rst_n),
      .en_i   (state == WS_IDLE),
      .elig_i (elig),
      .gnt_o  (grant)
   );

   wgc_fsm #(.N(NSRC)) u_fsm (
      .clk     (clk),
      .rst_n   (rst_n),
      .gnt_i   (grant),
      .cross_i (dcross_q),
      .done_i  (walk_done),
      .state_o (state),
      .owner_o (owner),
      .cross_o (walk_cross)
   );

   assign busy        = (state == WS_WALK);
   assign fin         = busy & walk_done;
   assign rsp_ok      = (fin && !walk_fault) ? owner : '0;
   assign rsp_fault   = (fin &&  walk_fault) ? owner : '0;
   assign mis_resume  = rsp_ok[SRC_DAT] & walk_cross;
   assign mis_restart = rsp_fault[SRC_DAT] & walk_cross;
   assign lookup_open = ~busy | owner[SRC_PFQ];

   p_igate_r1: assert property (@(posedge clk) disable iff (!rst_n)
      grant[SRC_INS] |-> (cb_empty && csq_empty && ibuf_empty && !exc_pending));
   p_dgate_r2: assert property (@(posedge clk) disable iff (!rst_n)
      grant[SRC_DAT] |-> (dacc_required && !exc_pending));
   p_pgate_r3: assert property (@(posedge clk) disable iff (!rst_n)
      grant[SRC_PFQ] |-> pf_retired);
   p_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));
   p_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (grant == '0));
   p_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (|grant) |=> busy);
   p_rsp_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((rsp_ok | rsp_fault) != '0) |-> (busy && walk_done));
   p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
      mis_restart |-> rsp_fault[SRC_DAT]);
endmodule

// File: tb/walk_gate_ctrl_tb_top.sv
module walk_gate_ctrl_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic imiss_req, dmiss_req, dmiss_cross, pf_req, pf_retired, flush;
   logic cb_empty, csq_empty, ibuf_empty, exc_pending, dacc_required;
   logic walk_done, walk_fault;
   logic [2:0] grant, rsp_ok, rsp_fault;
   logic busy, mis_resume, mis_restart, lookup_open;

   walk_gate_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .imiss_req(imiss_req), .dmiss_req(dmiss_req),
      .dmiss_cross(dmiss_cross), .pf_req(pf_req), .pf_retired(pf_retired),
      .flush(flush), .cb_empty(cb_empty), .csq_empty(csq_empty),
      .ibuf_empty(ibuf_empty), .exc_pending(exc_pending),
      .dacc_required(dacc_required), .walk_done(walk_done),
      .walk_fault(walk_fault), .grant(grant), .busy(busy), .rsp_ok(rsp_ok),
      .rsp_fault(rsp_fault), .mis_resume(mis_resume), .mis_restart(mis_restart),
      .lookup_open(lookup_open));

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   // bench expectation state
   logic [2:0] m_pend = '0, m_owner = '0, m_grant = '0;
   logic m_busy = 0, m_cross = 0, m_dcross = 0;

   task automatic chk(input string tag, input logic [2:0] act, input logic [2:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%b expected=%b", tag, act, exp);
      end
   endtask

   function automatic logic [2:0] f_grant();
      logic ei, ed, ep;
      ei = m_pend[0] & cb_empty & csq_empty & ibuf_empty & ~exc_pending & ~flush;
      ed = m_pend[1] & dacc_required & ~exc_pending & ~flush;
      ep = m_pend[2] & pf_retired & ~flush;
      if (m_busy) return 3'b000;
      if (ei) return 3'b001;
      if (ed) return 3'b010;
      if (ep) return 3'b100;
      return 3'b000;
   endfunction

   task automatic quiet();
      imiss_req = 0; dmiss_req = 0; dmiss_cross = 0; pf_req = 0; flush = 0;
      pf_retired = 1; cb_empty = 1; csq_empty = 1; ibuf_empty = 1;
      exc_pending = 0; dacc_required = 1; walk_done = 0; walk_fault = 0;
   endtask

   // called just after a falling edge with inputs already set
   task automatic drive_chk();
      logic [2:0] rok, rf;
      #1;
      m_grant = f_grant();
      rok = (m_busy && walk_done && !walk_fault) ? m_owner : 3'b000;
      rf  = (m_busy && walk_done &&  walk_fault) ? m_owner : 3'b000;
      chk("R1/R2/R3 gating with R5 priority: grant", grant, m_grant);
      chk("R7 busy", {2'b0, busy}, {2'b0, m_busy});
      chk("R8 rsp_ok", rsp_ok, rok);
      chk("R8 rsp_fault", rsp_fault, rf);
      chk("R9 mis_resume", {2'b0, mis_resume}, {2'b0, rok[1] & m_cross});
      chk("R9 mis_restart", {2'b0, mis_restart}, {2'b0, rf[1] & m_cross});
      chk("R10 lookup_open", {2'b0, lookup_open}, {2'b0, ~m_busy | m_owner[2]});
   endtask

   task automatic tick();
      logic old_dc;
      @(posedge clk);
      old_dc = m_dcross;
      m_pend = flush ? 3'b000 : ((m_pend & ~m_grant) | {pf_req, dmiss_req, imiss_req});
      if (flush) m_dcross = 0; else if (dmiss_req) m_dcross = dmiss_cross;
      if (!m_busy) begin
         if (|m_grant) begin
            m_busy = 1; m_owner = m_grant; m_cross = m_grant[1] & old_dc;
         end
      end else if (walk_done) m_busy = 0;
      @(negedge clk);
   endtask

   task automatic step();
      drive_chk();
      tick();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++; checks++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd2024));
      quiet();
      repeat (3) @(negedge clk);
      rst_n = 1;
      #1;
      chk("reset grant R5", grant, 3'b000);
      chk("reset busy R7", {2'b0, busy}, 3'b000);
      chk("reset lookup_open R10", {2'b0, lookup_open}, 3'b001);

      // R1: each gating flag lowered on its own blocks the instruction grant
      cb_empty = 0; imiss_req = 1; step(); imiss_req = 0;
      step(); chk("R1 cb_empty low", grant, 3'b000);
      cb_empty = 1; csq_empty = 0;
      step(); chk("R1 csq_empty low", grant, 3'b000);
      csq_empty = 1; ibuf_empty = 0;
      step(); chk("R1 ibuf_empty low", grant, 3'b000);
      ibuf_empty = 1; exc_pending = 1;
      step(); chk("R1 exc_pending high", grant, 3'b000);
      exc_pending = 0;
      drive_chk(); chk("R1/R6 held request granted", grant, 3'b001); tick();
      walk_done = 1; drive_chk(); chk("R8 instr ok", rsp_ok, 3'b001); tick();
      walk_done = 0;

      // R2 gating
      dacc_required = 0; dmiss_req = 1; step(); dmiss_req = 0;
      step(); chk("R2 not required", grant, 3'b000);
      dacc_required = 1; exc_pending = 1;
      step(); chk("R2 exception pending", grant, 3'b000);
      exc_pending = 0;
      drive_chk(); chk("R2 data granted", grant, 3'b010); tick();
      drive_chk(); chk("R10 closed in data walk", {2'b0, lookup_open}, 3'b000); tick();
      walk_done = 1; step(); walk_done = 0;

      // R3/R4 prefetch waits for retire, then goes at once
      pf_retired = 0; pf_req = 1; step(); pf_req = 0;
      step(); chk("R3 unretired wait", grant, 3'b000);
      step(); chk("R3 unretired still waiting", grant, 3'b000);
      pf_retired = 1;
      drive_chk(); chk("R4 retired grant", grant, 3'b100); tick();
      drive_chk(); chk("R10 open in prefetch walk", {2'b0, lookup_open}, 3'b001);
      chk("R7 busy in walk", {2'b0, busy}, 3'b001); tick();
      walk_done = 1; walk_fault = 1; drive_chk();
      chk("R8 prefetch fault", rsp_fault, 3'b100); tick();
      walk_done = 0; walk_fault = 0;

      // R5 three-way collision
      imiss_req = 1; dmiss_req = 1; pf_req = 1; step();
      imiss_req = 0; dmiss_req = 0; pf_req = 0;
      drive_chk(); chk("R5 instr first", grant, 3'b001); tick();
      drive_chk(); chk("R5 no grant while busy", grant, 3'b000); tick();
      walk_done = 1; step(); walk_done = 0;
      drive_chk(); chk("R5 data second", grant, 3'b010); tick();
      walk_done = 1; step(); walk_done = 0;
      drive_chk(); chk("R5 prefetch third", grant, 3'b100); tick();
      walk_done = 1; step(); walk_done = 0;

      // R6 flush cancels pending
      dacc_required = 0; dmiss_req = 1; step(); dmiss_req = 0;
      flush = 1; step(); flush = 0; dacc_required = 1;
      step(); chk("R6 flushed request gone", grant, 3'b000);

      // R9 misaligned resume and restart
      dmiss_req = 1; dmiss_cross = 1; step(); dmiss_req = 0; dmiss_cross = 0;
      step();
      walk_done = 1; drive_chk(); chk("R9 resume", {2'b0, mis_resume}, 3'b001); tick();
      dmiss_req = 1; dmiss_cross = 1; walk_done = 0; step();
      dmiss_req = 0; dmiss_cross = 0; step();
      walk_done = 1; walk_fault = 1; drive_chk();
      chk("R9 restart", {2'b0, mis_restart}, 3'b001);
      chk("R9 fault to data", rsp_fault, 3'b010); tick();
      quiet();

      // seeded random traffic
      for (int n = 0; n < 4000; n++) begin
         imiss_req     = ($urandom % 4) == 0;
         dmiss_req     = ($urandom % 4) == 0;
         dmiss_cross   = $urandom % 2;
         pf_req        = ($urandom % 4) == 0;
         pf_retired    = ($urandom % 3) != 0;
         cb_empty      = ($urandom % 8) != 0;
         csq_empty     = ($urandom % 8) != 0;
         ibuf_empty    = ($urandom % 8) != 0;
         exc_pending   = ($urandom % 8) == 0;
         dacc_required = ($urandom % 4) != 0;
         flush         = ($urandom % 32) == 0;
         walk_done     = ($urandom % 4) == 0;
         walk_fault    = $urandom % 2;
         step();
      end

      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule